// File: doc/BRIEF.md
# DMA Region Access Mask Filter

This block holds one bank of 32-bit DMA channel control registers: an event register, a channel enable register, an interrupt enable register and an interrupt pending register. The bank is reached through two kinds of window on a plain register bus. The global window sees every bit. Each of several region windows aliases the same physical registers, but every bit N is gated by bit N of that region's own access mask. A zero mask bit reads back as zero, is protected from writes, and is kept out of that region's interrupt.

Software first programs the per-region masks through the global window; at reset every mask is clear, so no region reaches any bit. Pending bits are raised by a test input, cleared by writing ones, and together with enable and interrupt enable they form one registered interrupt line per region.

The register bus is a plain single-cycle port with no back-pressure. A write commits at the rising clock edge while `wr_en_i` is high. Read data is combinational on `addr_i` and shows the state before that edge's write.

Top module: `dma_rmf_top`

## Requirements
- R1: After reset every mask register, every channel register and every interrupt output is 0.
- R2: The mask of region j is a read/write register at global byte address 0x100 + 8*j. The word addresses in between (0x104, 0x10C, ...) are unmapped.
- R3: Region j occupies byte addresses 0x200 + 32*j through 0x20C + 32*j. From its base, offsets 0x0, 0x4, 0x8 and 0xC select event, enable, interrupt enable and pending. A read there returns the channel register ANDed with the mask of region j.
- R4: A write to event, enable or interrupt enable through region j changes only the bits set in the mask of region j. Every other bit keeps its value.
- R5: The global window at byte addresses 0x0, 0x4, 0x8 and 0xC (event, enable, interrupt enable, pending) reads and writes all 32 bits unmasked.
- R6: Pending is write-1-to-clear. Through region j, only the ones that are also set in its mask clear. A bit of `pend_set_i` high in a cycle sets pending in that cycle and takes precedence over a clear in the same cycle.
- R7: A region window has no path to the mask registers. Region offsets 0x10 to 0x1C are unmapped, and no write inside any region window changes any mask.
- R8: Reads of unaligned or unmapped addresses return 0, and writes to them change no register.
- R9: `irq_o[j]` is the OR over bits of pending AND enable AND interrupt enable AND mask j. It is registered, so it reflects the register state one clock after that state is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W (12) | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe, commits at the clock edge |
| wr_data_i | input | DATA_W (32) | Write data |
| rd_data_o | output | DATA_W (32) | Combinational read data for addr_i |
| pend_set_i | input | DATA_W (32) | Test input that sets pending bits |
| irq_o | output | NUM_REGIONS (4) | Registered per-region interrupt lines |

## Verification
The bench builds the block with four regions, 32 data bits and a 12-bit address. This places the last mask at 0x118 and the last region window at 0x260, and makes the first address past the last window (0x280) an unmapped boundary. With four regions, random masks can overlap, nest and leave gaps. Randomly mixed writes through every window, together with pending sets, then exercise aliasing, partial clears and the set-over-clear collision. Directed cases pin the reset state, disjoint half-word masks on regions 0 and 1, and writes aimed at the unmapped tail of a region window.

// File: rtl/dma_rmf_pkg.sv
package dma_rmf_pkg;
  typedef enum logic [1:0] {
    CH_EVT = 2'd0,
    CH_ENA = 2'd1,
    CH_IEN = 2'd2,
    CH_PND = 2'd3
  } chan_sel_e;
endpackage

// File: rtl/dma_rmf_decode.sv
module dma_rmf_decode
  import dma_rmf_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int NUM_REGIONS = 4,
  parameter int MASK_BASE   = 256,
  parameter int REGION_BASE = 512,
  parameter int IDX_W       = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_chan,
  output logic              hit_region,
  output logic [IDX_W-1:0]  region_idx,
  output chan_sel_e         chan_sel,
  output logic              hit_mask,
  output logic [IDX_W-1:0]  mask_idx
);
  localparam int MASK_STRIDE = 8;
  localparam int REGION_SPAN = 32;
  localparam logic [ADDR_W-1:0] MASK_LO   = ADDR_W'(MASK_BASE);
  localparam logic [ADDR_W-1:0] MASK_HI   = ADDR_W'(MASK_BASE + MASK_STRIDE * NUM_REGIONS);
  localparam logic [ADDR_W-1:0] REGION_LO = ADDR_W'(REGION_BASE);
  localparam logic [ADDR_W-1:0] REGION_HI = ADDR_W'(REGION_BASE + REGION_SPAN * NUM_REGIONS);

  logic [ADDR_W-1:0] moff, roff;

  always_comb begin
    moff       = addr - MASK_LO;
    roff       = addr - REGION_LO;
    hit_chan   = 1'b0;
    hit_region = 1'b0;
    hit_mask   = 1'b0;
    region_idx = '0;
    mask_idx   = '0;
    chan_sel   = CH_EVT;
    if (addr[ADDR_W-1:4] == '0 && addr[1:0] == 2'b00) begin
      hit_chan = 1'b1;
      chan_sel = chan_sel_e'(addr[3:2]);
    end else if (addr >= MASK_LO && addr < MASK_HI && moff[2:0] == 3'b000) begin
      hit_mask = 1'b1;
      mask_idx = IDX_W'(moff >> 3);
    end else if (addr >= REGION_LO && addr < REGION_HI &&
                 roff[4] == 1'b0 && roff[1:0] == 2'b00) begin
      hit_chan   = 1'b1;
      hit_region = 1'b1;
      region_idx = IDX_W'(roff >> 5);
      chan_sel   = chan_sel_e'(roff[3:2]);
    end
  end
endmodule

// File: rtl/dma_rmf_chan_regs.sv
module dma_rmf_chan_regs
  import dma_rmf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  chan_sel_e         sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] wmask,
  input  logic [DATA_W-1:0] pend_set,
  output logic [DATA_W-1:0] evt_q,
  output logic [DATA_W-1:0] ena_q,
  output logic [DATA_W-1:0] ien_q,
  output logic [DATA_W-1:0] pnd_q
);
  logic [DATA_W-1:0] clr;

  always_comb clr = (wr_en && sel == CH_PND) ? (wdata & wmask) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= '0;
      ena_q <= '0;
      ien_q <= '0;
      pnd_q <= '0;
    end else begin
      if (wr_en && sel == CH_EVT) evt_q <= (evt_q & ~wmask) | (wdata & wmask);
      if (wr_en && sel == CH_ENA) ena_q <= (ena_q & ~wmask) | (wdata & wmask);
      if (wr_en && sel == CH_IEN) ien_q <= (ien_q & ~wmask) | (wdata & wmask);
      pnd_q <= (pnd_q & ~clr) | pend_set;
    end
  end
endmodule

// File: rtl/dma_rmf_irq.sv
module dma_rmf_irq #(
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [DATA_W-1:0]                   active,
  input  logic [NUM_REGIONS-1:0][DATA_W-1:0]  masks,
  output logic [NUM_REGIONS-1:0]              irq
);
  for (genvar j = 0; j < NUM_REGIONS; j++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) irq[j] <= 1'b0;
      else        irq[j] <= |(active & masks[j]);
    end
  end
endmodule

// File: rtl/dma_rmf_top.sv
module dma_rmf_top
  import dma_rmf_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int MASK_BASE   = 256,
  parameter int REGION_BASE = 512
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   wr_en_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic [DATA_W-1:0]      rd_data_o,
  input  logic [DATA_W-1:0]      pend_set_i,
  output logic [NUM_REGIONS-1:0] irq_o
);
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  logic                                hit_chan, hit_region, hit_mask;
  logic [IDX_W-1:0]                    region_idx, mask_idx;
  chan_sel_e                           chan_sel;
  logic [NUM_REGIONS-1:0][DATA_W-1:0]  mask_q;
  logic [DATA_W-1:0]                   sel_mask, chan_val, active;
  logic [DATA_W-1:0]                   evt_q, ena_q, ien_q, pnd_q;

  dma_rmf_decode #(
    .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .MASK_BASE(MASK_BASE),
    .REGION_BASE(REGION_BASE), .IDX_W(IDX_W)
  ) u_dec (
    .addr(addr_i), .hit_chan(hit_chan), .hit_region(hit_region),
    .region_idx(region_idx), .chan_sel(chan_sel), .hit_mask(hit_mask),
    .mask_idx(mask_idx)
  );

  for (genvar j = 0; j < NUM_REGIONS; j++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n) mask_q[j] <= '0;
      else if (wr_en_i && hit_mask && mask_idx == IDX_W'(j)) mask_q[j] <= wr_data_i;
    end
  end

  always_comb sel_mask = hit_region ? mask_q[region_idx] : '1;

  dma_rmf_chan_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i && hit_chan), .sel(chan_sel),
    .wdata(wr_data_i), .wmask(sel_mask), .pend_set(pend_set_i),
    .evt_q(evt_q), .ena_q(ena_q), .ien_q(ien_q), .pnd_q(pnd_q)
  );

  always_comb begin
    unique case (chan_sel)
      CH_EVT:  chan_val = evt_q;
      CH_ENA:  chan_val = ena_q;
      CH_IEN:  chan_val = ien_q;
      default: chan_val = pnd_q;
    endcase
    if (hit_chan)      rd_data_o = chan_val & sel_mask;
    else if (hit_mask) rd_data_o = mask_q[mask_idx];
    else               rd_data_o = '0;
  end

  always_comb active = pnd_q & ien_q & ena_q;

  dma_rmf_irq #(.DATA_W(DATA_W), .NUM_REGIONS(NUM_REGIONS)) u_irq (
    .clk(clk), .rst_n(rst_n), .active(active), .masks(mask_q), .irq(irq_o)
  );
endmodule

// File: rtl/dma_rmf_chk.sv
module dma_rmf_chk
  import dma_rmf_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 2
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               wr_en_i,
  input logic [DATA_W-1:0]                  pend_set_i,
  input logic [DATA_W-1:0]                  rd_data_o,
  input logic [NUM_REGIONS-1:0]             irq_o,
  input logic [NUM_REGIONS-1:0][DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0]                  evt_q,
  input logic [DATA_W-1:0]                  ena_q,
  input logic [DATA_W-1:0]                  ien_q,
  input logic [DATA_W-1:0]                  pnd_q,
  input logic                               hit_chan,
  input logic                               hit_region,
  input logic                               hit_mask,
  input logic [IDX_W-1:0]                   region_idx,
  input chan_sel_e                          chan_sel
);
  logic [DATA_W-1:0] reg_mask;
  logic              rw_ena, rw_evt;

  always_comb begin
    reg_mask = mask_q[region_idx];
    rw_ena   = wr_en_i && hit_region && chan_sel == CH_ENA;
    rw_evt   = wr_en_i && hit_region && chan_sel == CH_EVT;
  end

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == '0 && evt_q == '0 && ena_q == '0 &&
                      ien_q == '0 && pnd_q == '0 && irq_o == '0));

  p_rdata_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_region |-> (rd_data_o & ~reg_mask) == '0);

  p_ena_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rw_ena |=> ((ena_q ^ $past(ena_q)) & ~$past(reg_mask)) == '0);

  p_evt_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rw_evt |=> ((evt_q ^ $past(evt_q)) & ~$past(reg_mask)) == '0);

  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set_i != '0) |=> (pnd_q & $past(pend_set_i)) == $past(pend_set_i));

  p_region_no_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && hit_region) |=> $stable(mask_q));

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_chan && !hit_mask) |-> rd_data_o == '0);

  for (genvar j = 0; j < NUM_REGIONS; j++) begin : g_irq
    p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[j] |-> $past(mask_q[j]) != '0);
    p_irq_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[j] |-> $past(pnd_q & ien_q & ena_q) != '0);
  end
endmodule

bind dma_rmf_top dma_rmf_chk #(
  .NUM_REGIONS(NUM_REGIONS), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .pend_set_i(pend_set_i),
  .rd_data_o(rd_data_o), .irq_o(irq_o), .mask_q(mask_q), .evt_q(evt_q),
  .ena_q(ena_q), .ien_q(ien_q), .pnd_q(pnd_q), .hit_chan(hit_chan),
  .hit_region(hit_region), .hit_mask(hit_mask), .region_idx(region_idx),
  .chan_sel(chan_sel)
);

// File: tb/dma_rmf_top_tb.sv
`timescale 1ns/1ps
module dma_rmf_top_tb;
  localparam int NR = 4;
  localparam int DW = 32;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          wr_en_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [DW-1:0] pend_set_i = '0;
  logic [NR-1:0] irq_o;

  int n_checks = 0;
  int n_fail   = 0;

  logic [DW-1:0] m_mask [NR];
  logic [DW-1:0] m_chan [4];   // 0 event, 1 enable, 2 int enable, 3 pending
  logic [NR-1:0] exp_irq;

  always #5 clk = ~clk;

  dma_rmf_top #(.NUM_REGIONS(NR), .DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .pend_set_i(pend_set_i),
    .irq_o(irq_o)
  );

  // Address class: 0 unmapped, 1 global channel, 2 mask, 3 region channel
  function automatic int classify(input int a, output int idx, output int ch);
    idx = 0; ch = 0;
    if (a % 4 != 0) return 0;
    if (a < 16) begin ch = a / 4; return 1; end
    if (a >= 256 && a < 256 + 8 * NR && (a - 256) % 8 == 0) begin
      idx = (a - 256) / 8; return 2;
    end
    if (a >= 512 && a < 512 + 32 * NR && (a - 512) % 32 < 16) begin
      idx = (a - 512) / 32; ch = ((a - 512) % 32) / 4; return 3;
    end
    return 0;
  endfunction

  function automatic logic [DW-1:0] m_read(input int a);
    int idx, ch, c;
    c = classify(a, idx, ch);
    case (c)
      1: return m_chan[ch];
      2: return m_mask[idx];
      3: return m_chan[ch] & m_mask[idx];
      default: return '0;
    endcase
  endfunction

  function automatic logic [NR-1:0] m_irq();
    logic [NR-1:0] r;
    for (int j = 0; j < NR; j++)
      r[j] = |(m_chan[3] & m_chan[2] & m_chan[1] & m_mask[j]);
    return r;
  endfunction

  task automatic m_write(input int a, input logic we, input logic [DW-1:0] d,
                         input logic [DW-1:0] ps);
    int idx, ch, c;
    logic [DW-1:0] msk;
    logic [DW-1:0] clr;
    c = classify(a, idx, ch);
    clr = '0;
    if (we && (c == 1 || c == 3)) begin
      msk = (c == 3) ? m_mask[idx] : '1;
      if (ch == 3) clr = d & msk;
      else m_chan[ch] = (m_chan[ch] & ~msk) | (d & msk);
    end
    if (we && c == 2) m_mask[idx] = d;
    m_chan[3] = (m_chan[3] & ~clr) | ps;
  endtask

  function automatic string tag_of(input int a);
    int idx, ch, c;
    c = classify(a, idx, ch);
    case (c)
      1: return "R5";
      2: return "R2";
      3: return "R3";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input int a, input logic we, input logic [DW-1:0] d,
                    input logic [DW-1:0] ps, input string req);
    @(negedge clk);
    addr_i = AW'(a); wr_en_i = we; wr_data_i = d; pend_set_i = ps;
    #1;
    check(req, rd_data_o, m_read(a));
    check("R9", DW'(irq_o), DW'(exp_irq));
    exp_irq = m_irq();
    m_write(a, we, d, ps);
  endtask

  task automatic rd(input int a, input string req);
    op(a, 1'b0, '0, '0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    for (int j = 0; j < NR; j++) m_mask[j] = '0;
    for (int c = 0; c < 4; c++) m_chan[c] = '0;
    exp_irq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of channels, masks and interrupts
    for (int c = 0; c < 4; c++) rd(4 * c, "R1");
    for (int j = 0; j < NR; j++) rd(256 + 8 * j, "R1");
    check("R1", DW'(irq_o), '0);

    // R5 global write and read; R3 region with cleared mask reads zero
    op(0, 1'b1, 32'hA5A5_5A5A, '0, "R5");
    rd(0, "R5");
    rd(512, "R3");

    // R2 mask programming, with an unmapped gap word (R8)
    op(256, 1'b1, 32'h0000_FFFF, '0, "R2");
    op(264, 1'b1, 32'hFFFF_0000, '0, "R2");
    rd(256, "R2");
    rd(264, "R2");
    rd(260, "R8");
    op(260, 1'b1, 32'hFFFF_FFFF, '0, "R8");
    rd(256, "R8");

    // R4 region write only reaches masked bits
    op(512 + 4, 1'b1, 32'hFFFF_FFFF, '0, "R4");
    rd(4, "R4");
    op(512 + 32 + 4, 1'b1, 32'h0000_0000, '0, "R4");
    rd(4, "R4");

    // R9 interrupt from region 0 only
    op(8, 1'b1, 32'hFFFF_FFFF, 32'h0001_0001, "R9");
    rd(12, "R9");
    rd(12, "R9");

    // R6 region 1 clears only its bits; set wins over clear
    op(512 + 32 + 12, 1'b1, 32'hFFFF_FFFF, '0, "R6");
    rd(12, "R6");
    op(12, 1'b1, 32'h0000_0020, 32'h0000_0020, "R6");
    rd(12, "R6");

    // R7 writes into region tail cannot reach masks
    op(512 + 16, 1'b1, 32'hDEAD_BEEF, '0, "R7");
    op(512 + 32 + 24, 1'b1, 32'h1234_5678, '0, "R7");
    rd(256, "R7");
    rd(264, "R7");
    rd(512 + 16, "R7");
    rd(512 + 32 * NR, "R8");

    // Constrained random mix
    for (int i = 0; i < 6000; i++) begin
      int a, k;
      logic we;
      logic [DW-1:0] d, ps;
      k = int'($urandom % 8);
      case (k)
        0, 1: a = 4 * int'($urandom % 4);
        2:    a = 256 + 4 * int'($urandom % (2 * NR));
        3, 4, 5: a = 512 + 32 * int'($urandom % NR) + 4 * int'($urandom % 4);
        6:    a = int'($urandom % 4096);
        default: a = 512 + 32 * int'($urandom % (NR + 1)) + 16 + 4 * int'($urandom % 4);
      endcase
      we = 1'($urandom % 2);
      d  = ($urandom % 4 == 0) ? '1 : $urandom;
      ps = ($urandom % 4 == 0) ? ($urandom & $urandom & $urandom) : '0;
      op(a, we, d, ps, tag_of(a));
    end

    rd(0, "R5");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule